// File: doc/BRIEF.md
# Indexed Colour Palette Store

This block holds the colour table that an indexed-colour display pipeline uses to turn a small pixel code into a full RGB888 colour. The table has 256 colour entries of 16 bits each. A processor-side port sees them as 128 words of 32 bits, two entries per word. Each entry carries a 5-bit red, a 5-bit green and a 5-bit blue field plus one intensity flag.

The bus side writes a whole word when its write strobe is high. It reads back the raw 32-bit word one cycle after presenting the address, intensity flags included. The display side presents an 8-bit pixel index every cycle. On the next cycle it receives the selected entry widened to 8 bits per channel, and the intensity flag plays no part in that colour.

Both ports read the stored contents as they stood before the clock edge. A lookup or readback that meets a write to the same word in the same cycle therefore sees the previous value. Reset clears the whole table and both outputs to zero.

Top module: `pal_ram_top`

## Requirements
- R1: When `bus_we` is high at a rising clock edge, `bus_wdata` is stored in word `bus_addr` (0 to 127). When `bus_we` is low, `bus_wdata` has no effect on the stored contents.
- R2: `bus_rdata` shows, one cycle after `bus_addr` is presented, the word stored at that address before that edge. A write to the same word in the same cycle is not yet visible.
- R3: Pixel index `i` selects entry `i`. Word `i>>1` holds it, in bits [15:0] when `i` is even and in bits [31:16] when `i` is odd.
- R4: Within an entry, bits [4:0] are red, [9:5] green and [14:10] blue. `lu_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R5: Each 5-bit field widens to 8 bits as the field followed by three zero bits, so bits [2:0] of every output byte are zero.
- R6: The intensity flag (bit 15 of an entry, i.e. bit 15 or bit 31 of a word) has no effect on `lu_rgb`.
- R7: `lu_rgb` is registered. It shows the colour for the `lu_idx` presented one cycle earlier.
- R8: When a bus write and a lookup address the same word in the same cycle, the lookup returns the colour from the value held before the write.
- R9: Reset clears every stored word to zero and drives `bus_rdata` and `lu_rgb` to zero.
- R10: Bus readback returns all 32 bits exactly as last written, including both intensity flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | 7 | Word address for write and readback |
| bus_wdata | input | 32 | Word to store |
| bus_rdata | output | 32 | Raw word readback, one cycle after address |
| lu_idx | input | 8 | Pixel index to look up |
| lu_rgb | output | 24 | Expanded colour, one cycle after index |

## Verification
The bench builds the block with its default parameters: 128 words, 5-bit fields and 8-bit channels. At these values a directed sweep can write and read back every word and look up all 256 indices in a few hundred cycles, which reaches both halves of every word and the highest address. Fields are 5 bits and channels 8 bits, so a zero-filled low triplet in each output byte is visible at the ports. Word patterns set the intensity flags independently of the colour fields. Same-cycle write and lookup of one word, writes with the strobe low, and a reset in mid-run are driven on purpose to expose the read-before-write and clearing behaviour.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Number of colour channels in an entry and in the output.
    localparam int unsigned NUM_CH = 3;

    // Number of palette entries packed into one bus word.
    localparam int unsigned ENTRIES_PER_WORD = 2;

    // Channel order inside an entry, lowest field first.
    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

endpackage

// File: rtl/pal_store.sv
// Word-organised storage of the palette. Writes land on the clock edge;
// both read paths observe the contents held before that edge.
module pal_store #(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [WORD_W-1:0] bus_rword,
    input  logic [ADDR_W-1:0] lu_raddr,
    output logic [WORD_W-1:0] lu_rword
);

    typedef logic [WORD_W-1:0] word_t;

    word_t mem_d [WORDS];
    word_t mem_q [WORDS];
    word_t rd_d;
    word_t rd_q;

    always_comb begin
        mem_d = mem_q;
        rd_d  = mem_q[bus_raddr];
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
            rd_q  <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign bus_rword = rd_q;
    assign lu_rword  = mem_q[lu_raddr];

endmodule

// File: rtl/pal_expand.sv
// Widens each colour field of one entry to a full output channel.
// Red lands in the top channel, blue in the bottom one.
module pal_expand #(
    parameter int unsigned COMP_W = 5,
    parameter int unsigned CH_W   = 8
) (
    input  logic [pal_pkg::NUM_CH*COMP_W-1:0] color,
    output logic [pal_pkg::NUM_CH*CH_W-1:0]   rgb
);

    import pal_pkg::*;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int unsigned OUT_LSB = (NUM_CH - 1 - c) * CH_W;
        localparam int unsigned IN_LSB  = c * COMP_W;
        if (CH_W > COMP_W) begin : g_pad
            assign rgb[OUT_LSB +: CH_W] =
                {color[IN_LSB +: COMP_W], {(CH_W - COMP_W){1'b0}}};
        end else begin : g_trim
            assign rgb[OUT_LSB +: CH_W] =
                color[IN_LSB + COMP_W - CH_W +: CH_W];
        end
    end

endmodule

// File: rtl/pal_lookup.sv
// Picks one entry out of a stored word, expands it and registers the colour.
module pal_lookup #(
    parameter int unsigned COMP_W = 5,
    parameter int unsigned CH_W   = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [pal_pkg::ENTRIES_PER_WORD*(pal_pkg::NUM_CH*COMP_W+1)-1:0] word,
    input  logic                                          upper,
    output logic [pal_pkg::NUM_CH*CH_W-1:0]               rgb
);

    import pal_pkg::*;

    localparam int unsigned COLOR_W = NUM_CH * COMP_W;
    localparam int unsigned ENTRY_W = COLOR_W + 1;
    localparam int unsigned RGB_W   = NUM_CH * CH_W;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
    } lu_state_t;

    logic [COLOR_W-1:0] color_sel;
    logic [RGB_W-1:0]   rgb_wide;
    logic               unused_intensity;
    lu_state_t          st_d;
    lu_state_t          st_q;

    // The intensity flags never reach the colour path.
    assign unused_intensity = word[ENTRY_W-1] ^ word[2*ENTRY_W-1];

    assign color_sel = upper ? word[ENTRY_W +: COLOR_W] : word[0 +: COLOR_W];

    pal_expand #(
        .COMP_W (COMP_W),
        .CH_W   (CH_W)
    ) u_expand (
        .color (color_sel),
        .rgb   (rgb_wide)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rgb = rgb_wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb = st_q.rgb;

endmodule

// File: rtl/pal_ram_top.sv
// Palette store with a word-wide bus port and a registered colour lookup.
module pal_ram_top #(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned COMP_W = 5,
    parameter int unsigned CH_W   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_we,
    input  logic [$clog2(WORDS)-1:0]               bus_addr,
    input  logic [2*(3*COMP_W+1)-1:0]              bus_wdata,
    output logic [2*(3*COMP_W+1)-1:0]              bus_rdata,
    input  logic [$clog2(WORDS):0]                 lu_idx,
    output logic [3*CH_W-1:0]                      lu_rgb
);

    import pal_pkg::*;

    localparam int unsigned ADDR_W  = $clog2(WORDS);
    localparam int unsigned ENTRY_W = NUM_CH * COMP_W + 1;
    localparam int unsigned WORD_W  = ENTRIES_PER_WORD * ENTRY_W;
    localparam int unsigned RGB_W   = NUM_CH * CH_W;

    logic [WORD_W-1:0] lu_word;

    pal_store #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .bus_raddr (bus_addr),
        .bus_rword (bus_rdata),
        .lu_raddr  (lu_idx[ADDR_W:1]),
        .lu_rword  (lu_word)
    );

    pal_lookup #(
        .COMP_W (COMP_W),
        .CH_W   (CH_W)
    ) u_lookup (
        .clk   (clk),
        .rst_n (rst_n),
        .word  (lu_word),
        .upper (lu_idx[0]),
        .rgb   (lu_rgb)
    );

endmodule

// File: rtl/pal_ram_chk.sv
module pal_ram_chk #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned COMP_W = 5,
    parameter int unsigned CH_W   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [2*(3*COMP_W+1)-1:0]   bus_wdata,
    input logic [2*(3*COMP_W+1)-1:0]   bus_rdata,
    input logic [ADDR_W:0]             lu_idx,
    input logic [3*CH_W-1:0]           lu_rgb
);

    localparam int unsigned ENTRY_W = 3 * COMP_W + 1;
    localparam int unsigned RGB_W   = 3 * CH_W;

    function automatic logic [RGB_W-1:0] widen(input logic [ENTRY_W-1:0] e);
        logic [RGB_W-1:0] r;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            r[(2 - c) * CH_W +: CH_W] = CH_W'(e[c * COMP_W +: COMP_W]) << (CH_W - COMP_W);
        end
        return r;
    endfunction

    function automatic logic [RGB_W-1:0] pad_mask();
        logic [RGB_W-1:0] m;
        m = '0;
        for (int c = 0; c < 3; c++) begin
            for (int b = 0; b < CH_W - COMP_W; b++) begin
                m[c * CH_W + b] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [RGB_W-1:0] PAD_MASK = pad_mask();

    // Cycles since reset, saturating at two, so $past depth stays in range.
    logic [1:0] age_q;
    logic       past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end
    assign past_ok = (age_q == 2'd2);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lu_rgb == '0 && bus_rdata == '0));

    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_rgb & PAD_MASK) == '0);

    // R2
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we, 2) && $past(bus_addr) == $past(bus_addr, 2))
        |-> bus_rdata == $past(bus_wdata, 2));

    // R4
    lookup_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we, 2) && !$past(lu_idx[0])
         && $past(lu_idx[ADDR_W:1]) == $past(bus_addr, 2))
        |-> lu_rgb == widen($past(bus_wdata[ENTRY_W-1:0], 2)));

    // R8
    collide_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we) && $past(bus_we, 2) && $past(lu_idx[0])
         && $past(bus_addr) == $past(bus_addr, 2)
         && $past(lu_idx[ADDR_W:1]) == $past(bus_addr))
        |-> lu_rgb == widen($past(bus_wdata[2*ENTRY_W-1:ENTRY_W], 2)));

endmodule

bind pal_ram_top pal_ram_chk #(
    .ADDR_W (ADDR_W),
    .COMP_W (COMP_W),
    .CH_W   (CH_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lu_idx    (lu_idx),
    .lu_rgb    (lu_rgb)
);

// File: tb/test_pal_ram_top.sv
`timescale 1ns/1ps
module test_pal_ram_top;

    localparam int WORDS = 128;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  lu_idx;
    logic [23:0] lu_rgb;

    always #2.5 clk = ~clk;

    pal_ram_top i_pal_ram_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lu_idx    (lu_idx),
        .lu_rgb    (lu_rgb)
    );

    typedef struct {
        logic [23:0] rgb;
        logic [31:0] rd;
        int          req_rgb;
        int          req_rd;
    } exp_t;

    exp_t        sbq[$];
    logic [31:0] mdl [WORDS];
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    // Expected colour from the field layout of R4/R5; bit 15 ignored (R6).
    function automatic logic [23:0] widen(input logic [15:0] e);
        return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
    endfunction

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: presents one cycle of stimulus and queues its expected result.
    task automatic step(input bit we, input int addr, input logic [31:0] wd,
                        input int idx, input int req_rgb, input int req_rd);
        exp_t        e;
        logic [31:0] w;
        @(negedge clk);
        bus_we    = we;
        bus_addr  = 7'(addr);
        bus_wdata = wd;
        lu_idx    = 8'(idx);
        w         = mdl[idx >> 1];
        e.rgb     = widen(idx[0] ? w[31:16] : w[15:0]);
        e.rd      = mdl[addr];
        e.req_rgb = req_rgb;
        e.req_rd  = req_rd;
        sbq.push_back(e);
        if (we) mdl[addr] = wd;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) mdl[i] = '0;
        @(negedge clk);
        // R9: outputs cleared while reset is held
        chk(lu_rgb == 24'h0, 9, "lu_rgb in reset", 32'(lu_rgb), 32'h0);
        chk(bus_rdata == 32'h0, 9, "bus_rdata in reset", bus_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops one expectation per edge and compares, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(lu_rgb == e.rgb, e.req_rgb, "lu_rgb", 32'(lu_rgb), 32'(e.rgb));
                chk(bus_rdata == e.rd, e.req_rd, "bus_rdata", bus_rdata, e.rd);
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        lu_idx    = '0;
        for (int i = 0; i < WORDS; i++) mdl[i] = '0;
        do_reset();

        // R9: every word and every index reads as zero after reset
        for (int i = 0; i < WORDS; i++) step(1'b0, i, 32'hFFFF_FFFF, 2 * i + 1, 9, 9);

        // R1, R10: fill every word, intensity flags varied per word
        for (int i = 0; i < WORDS; i++) begin
            logic [31:0] v;
            v = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
            v[15] = i[0];
            v[31] = i[1];
            step(1'b1, i, v, 0, 7, 1);
        end
        // R10, R2: raw readback of all words
        for (int i = 0; i < WORDS; i++) step(1'b0, i, 32'h0, 0, 7, 10);

        // R3, R4, R5, R7: look up every index, even and odd halves
        for (int i = 0; i < 256; i++) step(1'b0, i % WORDS, 32'h0, i, 3, 2);
        // R7: descending indices change every cycle
        for (int i = 255; i >= 0; i -= 7) step(1'b0, 0, 32'h0, i, 7, 2);

        // R4: one field at a time in word 5, low and high entries
        step(1'b1, 5, 32'h03E0_001F, 0, 7, 1);
        step(1'b0, 5, 32'h0, 10, 4, 2);
        step(1'b0, 5, 32'h0, 11, 4, 2);
        step(1'b1, 5, 32'h0000_7C00, 0, 7, 1);
        step(1'b0, 5, 32'h0, 10, 4, 2);

        // R6: same colour with and without the intensity flag
        step(1'b1, 9, 32'h2108_2108, 0, 7, 1);
        step(1'b0, 9, 32'h0, 18, 6, 10);
        step(1'b1, 9, 32'hA108_A108, 0, 7, 1);
        step(1'b0, 9, 32'h0, 18, 6, 10);
        step(1'b0, 9, 32'h0, 19, 6, 10);
        drain();
        chk(lu_rgb == 24'h404040, 6, "intensity flag ignored", 32'(lu_rgb), 32'h404040);

        // R1: strobe low leaves contents untouched
        step(1'b0, 20, 32'hDEAD_BEEF, 40, 1, 1);
        step(1'b0, 20, 32'h0, 41, 1, 1);

        // R8, R2: write and lookup/readback of the same word in one cycle
        step(1'b1, 33, 32'h7FFF_0000, 66, 8, 2);
        step(1'b1, 33, 32'h1234_4321, 67, 8, 2);
        step(1'b0, 33, 32'h0, 66, 8, 2);
        step(1'b1, 127, 32'hFFFF_FFFF, 255, 8, 2);
        step(1'b0, 127, 32'h0, 255, 8, 10);
        drain();

        // R9: reset in mid-run clears stored words
        do_reset();
        step(1'b0, 127, 32'h0, 254, 9, 9);
        step(1'b0, 33, 32'h0, 67, 9, 9);
        step(1'b0, 5, 32'h0, 11, 9, 9);
        drain();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule